// File: doc/BRIEF.md
# Power Domain Switch-On Sequencer

This block is a hardware state machine that takes one switchable power domain from fully off to fully on. It drives a seven-bit control word and a per-bank SRAM power-down vector. It also watches two power-good status buses and an SRAM acknowledge bus. A start pulse launches a fixed series of steps. Each step changes one control field in a clock cycle of its own, so the power switch, clock gate, isolation cells and reset see their changes in a known order.

Sequencing is locked until a configuration word carrying the right 16-bit key in its upper half and a 1 in bit 0 has been written. Writing the right key with bit 0 clear locks it again. Any other key is ignored. The status bit that marks this domain, the SRAM banks to power up and the SRAM acknowledge bits to watch are all parameters, so one source serves every domain of a chip. An optional timeout freezes the sequence and raises an error flag if either wait runs too long.

Top module: `pdom_seq_top`

## Requirements
- R1: After reset the control word `ctrl` reads 7'h32, every bit of `sram_pdn` is 1, and `busy`, `done` and `err` are 0. The control word bits are: bit0 reset release (1 = out of reset), bit1 isolation, bit2 primary switch, bit3 secondary switch, bit4 clock off, bit5 SRAM clock isolation, bit6 SRAM isolation release (active low).
- R2: A write with `cfg_wr` high and `cfg_data[31:16]` equal to `KEY_VAL` sets the unlock state to `cfg_data[0]`. A write with any other upper half changes nothing.
- R3: A `start` pulse is accepted only in the idle state while unlocked. A `start` while locked, or while a sequence is running, has no effect on `busy` or on the outputs.
- R4: The primary switch (bit2) turns on in the first cycle after an accepted start. The secondary switch (bit3) turns on in the next cycle.
- R5: After both switches are on, the sequence stalls until bit `STAT_BIT` is 1 in both `pwr_sta` and `pwr_sta2`. Other bits of those buses are ignored. Clock off clears two cycles after the cycle in which both status bits are first presented.
- R6: After power-good, the sequence clears clock off, then clears isolation, then releases reset, then clears the `PDN_MASK` bits of `sram_pdn`, in four consecutive cycles. The final word is `ctrl` = 7'h2D.
- R7: `done` rises one cycle after the cycle in which every `sram_ack` bit selected by `ACK_MASK` first reads 0. Acknowledge bits outside the mask are ignored.
- R8: `busy` is high from the cycle after an accepted start until `done` rises. It is never high together with `done`.
- R9: With `tmo_limit` nonzero, a wait that does not complete within the limit sets `err`, clears `busy`, and freezes `ctrl` and `sram_pdn` until reset. With `tmo_limit` = 0 a wait never times out.
- R10: Bits 5 and 6 of `ctrl` stay at 1 and 0 throughout.
- R11: When power-good and a clear acknowledge are already present, `done` is visible 8 clock edges after the edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 32 | Configuration word: key in [31:16], enable in [0] |
| start | input | 1 | One-cycle request to start the power-on sequence |
| tmo_limit | input | TMO_W | Wait timeout in cycles; 0 disables the timeout |
| pwr_sta | input | STAT_W | Primary power-good status bus |
| pwr_sta2 | input | STAT_W | Secondary power-good status bus |
| sram_ack | input | ACK_W | SRAM power acknowledge bits (1 = not yet powered) |
| ctrl | output | 7 | Domain control word |
| sram_pdn | output | BANKS | SRAM bank power-down bits (1 = off) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Domain fully on |
| err | output | 1 | A wait timed out |

## Verification
On every cycle the assertions check the following. The secondary switch never turns on before the primary one. Clock, isolation, reset and SRAM changes only follow their predecessors and, for the clock, confirmed power-good. `done` only follows a clear acknowledge. `busy` and `done` are exclusive. The two SRAM isolation bits never move. A faulted sequence stays frozen. Foreign-key writes leave the lock alone. The bench scenarios cover the rest: exact step spacing and latency, the use of the selected status bit only under decoy patterns on the other bits, start pulses ignored while locked or busy, relocking, and both timeout paths.

// File: rtl/pdom_pkg.sv
package pdom_pkg;

    localparam int CTRL_W = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PON1,
        ST_PON2,
        ST_PGWAIT,
        ST_CLKON,
        ST_ISOOFF,
        ST_RSTREL,
        ST_SRAMON,
        ST_ACKWAIT,
        ST_DONE,
        ST_FAULT
    } seq_st_e;

    // Packed MSB first: field order fixes the bit positions of the control word
    typedef struct packed {
        logic sram_iso_b;   // bit 6
        logic sram_ckiso;   // bit 5
        logic clk_off;      // bit 4
        logic pon2;         // bit 3
        logic pon;          // bit 2
        logic iso;          // bit 1
        logic rst_n;        // bit 0
    } ctrl_t;

    localparam ctrl_t CTRL_OFF = '{sram_iso_b: 1'b0, sram_ckiso: 1'b1, clk_off: 1'b1,
                                   pon2: 1'b0, pon: 1'b0, iso: 1'b1, rst_n: 1'b0};

    function automatic logic key_hit(input logic [31:0] word, input logic [15:0] key);
        return word[31:16] == key;
    endfunction

    function automatic logic is_wait(input seq_st_e s);
        return (s == ST_PGWAIT) || (s == ST_ACKWAIT);
    endfunction

endpackage

// File: rtl/pdom_key_gate.sv
module pdom_key_gate #(
    parameter logic [15:0] KEY_VAL = 16'h0B16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_data,
    output logic        unlocked
);
    import pdom_pkg::*;

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^cfg_data[15:1];

    always_ff @(posedge clk) begin
        if (rst)
            unlocked <= 1'b0;
        else if (cfg_wr && key_hit(cfg_data, KEY_VAL))
            unlocked <= cfg_data[0];
    end

    AST_FOREIGN_KEY_HELD: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_data[31:16] != KEY_VAL) |=> $stable(unlocked)); // R2

    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_data[31:16] == KEY_VAL && cfg_data[0]) |=> unlocked); // R2

endmodule

// File: rtl/pdom_wait_timer.sv
module pdom_wait_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !active)
            cnt_q <= '0;
        else if (cnt_q != limit)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = active && (limit != '0) && (cnt_q == limit);

    AST_TMO_RESTART: assert property (@(posedge clk) disable iff (rst)
        !active |=> cnt_q == '0); // R9

endmodule

// File: rtl/pdom_seq_fsm.sv
module pdom_seq_fsm #(
    parameter int               BANKS    = 4,
    parameter logic [BANKS-1:0] PDN_MASK = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              unlocked,
    input  logic              pg_ok,
    input  logic              ack_clear,
    input  logic              expired,
    output pdom_pkg::ctrl_t   ctrl_q,
    output logic [BANKS-1:0]  pdn_q,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              wait_active
);
    import pdom_pkg::*;

    seq_st_e st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            ctrl_q <= CTRL_OFF;
            pdn_q  <= '1;
            busy   <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start && unlocked) begin
                        busy <= 1'b1;
                        st_q <= ST_PON1;
                    end
                end
                ST_PON1: begin
                    ctrl_q.pon <= 1'b1;
                    st_q       <= ST_PON2;
                end
                ST_PON2: begin
                    ctrl_q.pon2 <= 1'b1;
                    st_q        <= ST_PGWAIT;
                end
                ST_PGWAIT: begin
                    if (pg_ok) begin
                        st_q <= ST_CLKON;
                    end else if (expired) begin
                        err  <= 1'b1;
                        busy <= 1'b0;
                        st_q <= ST_FAULT;
                    end
                end
                ST_CLKON: begin
                    ctrl_q.clk_off <= 1'b0;
                    st_q           <= ST_ISOOFF;
                end
                ST_ISOOFF: begin
                    ctrl_q.iso <= 1'b0;
                    st_q       <= ST_RSTREL;
                end
                ST_RSTREL: begin
                    ctrl_q.rst_n <= 1'b1;
                    st_q         <= ST_SRAMON;
                end
                ST_SRAMON: begin
                    pdn_q <= pdn_q & ~PDN_MASK;
                    st_q  <= ST_ACKWAIT;
                end
                ST_ACKWAIT: begin
                    if (ack_clear) begin
                        done <= 1'b1;
                        busy <= 1'b0;
                        st_q <= ST_DONE;
                    end else if (expired) begin
                        err  <= 1'b1;
                        busy <= 1'b0;
                        st_q <= ST_FAULT;
                    end
                end
                default: st_q <= st_q;
            endcase
        end
    end

    assign wait_active = is_wait(st_q);

    AST_PON2_AFTER_PON: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.pon2) |-> $past(ctrl_q.pon)); // R4

    AST_CLK_AFTER_PG: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_q.clk_off) |-> $past(pg_ok, 2)); // R5

    AST_ISO_AFTER_CLK: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_q.iso) |-> $past(!ctrl_q.clk_off)); // R6

    AST_RST_AFTER_ISO: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.rst_n) |-> $past(!ctrl_q.iso)); // R6

    AST_PDN_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        !$stable(pdn_q) |-> $past(ctrl_q.rst_n)); // R6

    AST_DONE_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(ack_clear)); // R7

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy && done)); // R8

    AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        err |=> ($stable(ctrl_q) && $stable(pdn_q) && !done)); // R9

    AST_SRAM_ISO_FIXED: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.sram_ckiso && !ctrl_q.sram_iso_b); // R10

    AST_LOCKED_START: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && start && !unlocked) |=> !busy); // R3

endmodule

// File: rtl/pdom_seq_top.sv
module pdom_seq_top #(
    parameter logic [15:0] KEY_VAL  = 16'h0B16,
    parameter int          STAT_W   = 32,
    parameter int          STAT_BIT = 3,
    parameter int          BANKS    = 4,
    parameter int          ACK_W    = 4,
    parameter logic [BANKS-1:0] PDN_MASK = 4'hF,
    parameter logic [ACK_W-1:0] ACK_MASK = 4'h7,
    parameter int          TMO_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [31:0]          cfg_data,
    input  logic                 start,
    input  logic [TMO_W-1:0]     tmo_limit,
    input  logic [STAT_W-1:0]    pwr_sta,
    input  logic [STAT_W-1:0]    pwr_sta2,
    input  logic [ACK_W-1:0]     sram_ack,
    output logic [6:0]           ctrl,
    output logic [BANKS-1:0]     sram_pdn,
    output logic                 busy,
    output logic                 done,
    output logic                 err
);
    import pdom_pkg::*;

    localparam logic [STAT_W-1:0] STAT_SEL = STAT_W'(1) << STAT_BIT;

    logic  unlocked;
    logic  pg_ok;
    logic  ack_clear;
    logic  expired;
    logic  wait_active;
    ctrl_t ctrl_s;

    assign pg_ok     = |(pwr_sta & STAT_SEL) && |(pwr_sta2 & STAT_SEL);
    assign ack_clear = (sram_ack & ACK_MASK) == '0;

    pdom_key_gate #(.KEY_VAL(KEY_VAL)) u_key (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (cfg_wr),
        .cfg_data (cfg_data),
        .unlocked (unlocked)
    );

    pdom_wait_timer #(.TMO_W(TMO_W)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .active  (wait_active),
        .limit   (tmo_limit),
        .expired (expired)
    );

    pdom_seq_fsm #(.BANKS(BANKS), .PDN_MASK(PDN_MASK)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .unlocked    (unlocked),
        .pg_ok       (pg_ok),
        .ack_clear   (ack_clear),
        .expired     (expired),
        .ctrl_q      (ctrl_s),
        .pdn_q       (sram_pdn),
        .busy        (busy),
        .done        (done),
        .err         (err),
        .wait_active (wait_active)
    );

    assign ctrl = ctrl_s;

    AST_SEC_NEEDS_PRI: assert property (@(posedge clk) disable iff (rst)
        ctrl[3] |-> ctrl[2]); // R4

endmodule

// File: tb/sim_pdom_seq_top.sv
`timescale 1ns/1ps
module sim_pdom_seq_top;

    localparam logic [15:0] KEY  = 16'h0B16;
    localparam int          SBIT = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [31:0] cfg_data;
    logic        start;
    logic [15:0] tmo_limit;
    logic [31:0] pwr_sta;
    logic [31:0] pwr_sta2;
    logic [3:0]  sram_ack;
    logic [6:0]  ctrl;
    logic [3:0]  sram_pdn;
    logic        busy;
    logic        done;
    logic        err;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pdom_seq_top u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data), .start(start),
        .tmo_limit(tmo_limit), .pwr_sta(pwr_sta), .pwr_sta2(pwr_sta2), .sram_ack(sram_ack),
        .ctrl(ctrl), .sram_pdn(sram_pdn), .busy(busy), .done(done), .err(err)
    );

    // Vector fields: primary status delay, secondary status delay, ack delay, decoy flag
    localparam logic [24:0] VEC [4] = '{
        {8'd0,  8'd0,  8'd0, 1'b0},
        {8'd3,  8'd7,  8'd2, 1'b1},
        {8'd10, 8'd1,  8'd5, 1'b0},
        {8'd0,  8'd20, 8'd0, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; cfg_wr = 1'b0; cfg_data = '0; start = 1'b0; tmo_limit = '0;
        pwr_sta = '0; pwr_sta2 = '0; sram_ack = 4'hF;
        repeat (3) tick();
        rst = 1'b0;
        tick();
    endtask

    task automatic cfg_write(input logic [15:0] key, input logic en);
        cfg_wr = 1'b1; cfg_data = {key, 15'd0, en};
        tick();
        cfg_wr = 1'b0; cfg_data = '0;
        tick();
    endtask

    task automatic pulse_start();
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic run_vec(input int pg1d, input int pg2d, input int ackd, input bit decoy);
        int t_pon = -1, t_pon2 = -1, t_pg = -1, t_clk = -1, t_iso = -1;
        int t_rst = -1, t_pdn = -1, t_ack = -1, t_done = -1;
        int busy_bad = 0, fixed_bad = 0;
        do_reset();
        cfg_write(KEY, 1'b1);
        pwr_sta  = decoy ? ~(32'd1 << SBIT) : 32'd0;
        pwr_sta2 = decoy ? ~(32'd1 << SBIT) : 32'd0;
        sram_ack = 4'hF;
        pulse_start();
        for (int c = 1; c <= 300; c++) begin
            tick();
            if (ctrl[2] && t_pon < 0)  t_pon  = c;
            if (ctrl[3] && t_pon2 < 0) t_pon2 = c;
            if (!ctrl[4] && t_clk < 0) t_clk  = c;
            if (!ctrl[1] && t_iso < 0) t_iso  = c;
            if (ctrl[0] && t_rst < 0)  t_rst  = c;
            if (sram_pdn == 4'h0 && t_pdn < 0) t_pdn = c;
            if (ctrl[5] !== 1'b1 || ctrl[6] !== 1'b0) fixed_bad++;
            if (done) begin t_done = c; break; end
            if (!busy) busy_bad++;
            if (t_pon2 >= 0 && c >= t_pon2 + pg1d) pwr_sta[SBIT]  = 1'b1;
            if (t_pon2 >= 0 && c >= t_pon2 + pg2d) pwr_sta2[SBIT] = 1'b1;
            if (pwr_sta[SBIT] && pwr_sta2[SBIT] && t_pg < 0) t_pg = c;
            if (t_pdn >= 0 && c >= t_pdn + ackd && t_ack < 0) begin
                sram_ack = 4'b1000; // bit 3 is outside the watched mask
                t_ack = c;
            end
        end
        chk(t_done > 0, "R7 done reached", t_done, 1);
        chk(t_pon == 1, "R4 primary switch cycle", t_pon, 1);
        chk(t_pon2 == t_pon + 1, "R4 secondary follows primary", t_pon2, t_pon + 1);
        chk(t_clk == t_pg + 2, "R5 clock on after power-good", t_clk, t_pg + 2);
        chk(t_iso == t_clk + 1, "R6 isolation after clock", t_iso, t_clk + 1);
        chk(t_rst == t_iso + 1, "R6 reset after isolation", t_rst, t_iso + 1);
        chk(t_pdn == t_rst + 1, "R6 sram after reset", t_pdn, t_rst + 1);
        chk(ctrl == 7'h2D, "R6 final control word", ctrl, 7'h2D);
        chk(t_done == t_ack + 1, "R7 done after ack clear", t_done, t_ack + 1);
        chk(busy_bad == 0 && !busy, "R8 busy until done", busy_bad, 0);
        chk(fixed_bad == 0, "R10 sram isolation bits fixed", fixed_bad, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired, run did not complete actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        chk(ctrl == 7'h32, "R1 ctrl after reset", ctrl, 7'h32);
        chk(sram_pdn == 4'hF, "R1 sram_pdn after reset", sram_pdn, 4'hF);
        chk({busy, done, err} == 3'b000, "R1 flags after reset", {busy, done, err}, 0);

        // R3 start while locked is ignored
        pulse_start();
        repeat (5) tick();
        chk(!busy && ctrl == 7'h32, "R3 start while locked", {busy, ctrl}, 7'h32);

        // R2 foreign key ignored
        cfg_write(KEY ^ 16'h0001, 1'b1);
        pulse_start();
        repeat (5) tick();
        chk(!busy && ctrl == 7'h32, "R2 foreign key ignored", {busy, ctrl}, 7'h32);

        // R2 right key with enable clear locks again
        cfg_write(KEY, 1'b1);
        cfg_write(KEY, 1'b0);
        pulse_start();
        repeat (5) tick();
        chk(!busy && ctrl == 7'h32, "R2 relock", {busy, ctrl}, 7'h32);

        // Vector table: varied delays and decoy status bits (R4 R5 R6 R7 R8 R10)
        for (int i = 0; i < 4; i++)
            run_vec(int'(VEC[i][24:17]), int'(VEC[i][16:9]), int'(VEC[i][8:1]), VEC[i][0]);

        // R3 start while busy is ignored
        do_reset();
        cfg_write(KEY, 1'b1);
        pulse_start();
        repeat (6) tick();
        chk(busy && ctrl == 7'h3E, "R3 stalled before second start", {busy, ctrl}, 8'hBE);
        pulse_start();
        repeat (3) tick();
        chk(busy && ctrl == 7'h3E && !done, "R3 second start ignored", {busy, ctrl}, 8'hBE);
        pwr_sta[SBIT] = 1'b1; pwr_sta2[SBIT] = 1'b1; sram_ack = 4'h0;
        repeat (8) tick();
        chk(done && !busy, "R3 sequence completes after ignored start", {done, busy}, 2'b10);

        // R9 timeout while waiting for power-good
        do_reset();
        cfg_write(KEY, 1'b1);
        tmo_limit = 16'd5;
        pulse_start();
        repeat (40) tick();
        chk(err && !busy && !done, "R9 power-good timeout flags", {err, busy, done}, 3'b100);
        chk(ctrl == 7'h3E, "R9 frozen ctrl", ctrl, 7'h3E);
        pwr_sta[SBIT] = 1'b1; pwr_sta2[SBIT] = 1'b1; sram_ack = 4'h0;
        repeat (12) tick();
        chk(ctrl == 7'h3E && !done && sram_pdn == 4'hF, "R9 stays frozen", ctrl, 7'h3E);

        // R9 timeout while waiting for acknowledge
        do_reset();
        cfg_write(KEY, 1'b1);
        tmo_limit = 16'd5;
        pwr_sta[SBIT] = 1'b1; pwr_sta2[SBIT] = 1'b1; sram_ack = 4'h1;
        pulse_start();
        repeat (40) tick();
        chk(err && !done && ctrl == 7'h2D && sram_pdn == 4'h0, "R9 ack timeout",
            {err, done, ctrl}, {2'b10, 7'h2D});

        // R9 limit zero disables timeout
        do_reset();
        cfg_write(KEY, 1'b1);
        pulse_start();
        repeat (60) tick();
        chk(!err && busy, "R9 no timeout when limit zero", {err, busy}, 2'b01);

        // R11 latency with feedback already present
        do_reset();
        cfg_write(KEY, 1'b1);
        pwr_sta[SBIT] = 1'b1; pwr_sta2[SBIT] = 1'b1; sram_ack = 4'h0;
        pulse_start();
        begin
            int n = 0;
            while (!done && n < 50) begin
                tick();
                n++;
            end
            chk(n == 8, "R11 start to done latency", n, 8);
        end

        summary();
        $finish;
    end

endmodule